// File: doc/BRIEF.md
# Serial Receive Interrupt Controller

This block sits between a serial receiver and the host bus. It holds received characters in an eight-entry queue. Each entry carries the data and four error flags. From the state of that queue, the block derives one receive interrupt-pending output and a two-bit vector status code.

The host can look at the character at the queue exit, and at its flags, without removing it. A read strobe removes the data and its flags together.

Three interrupt modes are selectable:
- **Off.** No receive interrupt is raised.
- **First-character.** One interrupt marks the start of a block, after which a DMA engine drains the rest. The host re-arms the interrupt with a command.
- **Every-character.** An interrupt is pending whenever a character waits. An optional threshold holds off the interrupt until four characters are queued.

A character with a special condition raises the special-condition code. In first-character mode it also freezes the queue exit until the host issues an error-reset command.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset the queue is empty (`head_valid_o`=0), `irq_pend_o`=0 and `vec_stat_o`=00.
- R2: Characters leave in arrival order. The exit entry is visible on `head_data_o`/`head_err_o` without being removed. An unlocked `rd_i` removes the data and its flags together. The flag bits are [3]=end-of-frame, [2]=framing, [1]=overrun, [0]=parity.
- R3: A push while 8 entries are held and no removal happens stores nothing and sets flag bit [1] of the newest entry. A push in the same cycle as a removal is stored normally, with no overrun.
- R4: With `mode_i` 00 or 11, `irq_pend_o` stays 0 and `vec_stat_o` stays 00, while reads still remove characters.
- R5: With `mode_i`=01, a waiting character raises `irq_pend_o` with `vec_stat_o`=01. This includes a character already queued when the mode is entered.
- R6: With `mode_i`=01, once a character is removed, no character-available interrupt occurs until a `rearm_i` pulse. After that pulse, a waiting character raises it again.
- R7: With `mode_i`=01, a special character at the exit raises `vec_stat_o`=10 and locks the queue. While locked, `rd_i` removes nothing, and the same data and flags stay readable.
- R8: An `err_reset_i` pulse while locked removes the offending character and unlocks the queue.
- R9: With `mode_i`=10 and `thresh_en_i`=0, `irq_pend_o` follows "exit occupied". Special characters give code 10, others 01, and special characters never lock.
- R10: With `mode_i`=10 and `thresh_en_i`=1, the character-available interrupt asserts at 4 or more held entries and drops below 4.
- R11: A character counts as special if any of these holds:
  - it has the overrun, framing or end-of-frame flag set;
  - it has the parity flag set and `par_en_i`=1.

  Flag bit [0] is shown regardless of `par_en_i`.
- R12: When the special and character-available conditions both hold, `vec_stat_o` reports 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Receiver delivers a character |
| push_data_i | input | 8 | Received character |
| push_perr_i | input | 1 | Parity error on that character |
| push_ferr_i | input | 1 | Framing error on that character |
| push_eof_i | input | 1 | Character ends a frame |
| rd_i | input | 1 | Host data read (removes exit entry) |
| mode_i | input | 2 | 00/11 off, 01 first-character, 10 every-character |
| thresh_en_i | input | 1 | Four-entry threshold in every-character mode |
| par_en_i | input | 1 | Parity errors count as special |
| rearm_i | input | 1 | Re-enable interrupt on next character |
| err_reset_i | input | 1 | Clear special condition and unlock |
| head_valid_o | output | 1 | Exit entry present |
| head_data_o | output | 8 | Exit entry data |
| head_err_o | output | 4 | Exit entry flags |
| irq_pend_o | output | 1 | Receive interrupt pending |
| vec_stat_o | output | 2 | 00 none, 01 character, 10 special |

## Verification
A push from the receiver and a removal by the host can land in the same cycle while the queue is full. In that case the removal must free the slot, so the push is stored and no overrun flag appears. The bench fills the queue to eight and then drives both strobes together. It then pushes once more alone, so the overrun mark must land on the character from the collision cycle. Draining the queue through the scoreboard then judges both the ordering and which entry carries the overrun flag.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    typedef struct packed {
        logic eof;
        logic ferr;
        logic ovr;
        logic perr;
    } rxi_err_t;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_FIRST = 2'b01,
        MODE_ALL   = 2'b10,
        MODE_OFF_B = 2'b11
    } rxi_mode_e;

    typedef enum logic [1:0] {
        VEC_NONE = 2'b00,
        VEC_CHAR = 2'b01,
        VEC_SPEC = 2'b10
    } rxi_vec_e;

endpackage

// File: rtl/rx_char_queue.sv
module rx_char_queue
    import rx_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic [DATA_W-1:0]             push_data_i,
    input  rxi_err_t                      push_err_i,
    input  logic                          pop_i,
    output logic [DATA_W-1:0]             head_data_o,
    output rxi_err_t                      head_err_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        rxi_err_t [DEPTH-1:0]         err;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic     full, do_pop, accept;

    always_comb begin
        st_d   = st_q;
        full   = (st_q.cnt == CNT_FULL);
        do_pop = pop_i && (st_q.cnt != '0);
        accept = push_i && (!full || do_pop);
        if (accept) begin
            st_d.data[st_q.wr]    = push_data_i;
            st_d.err[st_q.wr]     = push_err_i;
            st_d.err[st_q.wr].ovr = 1'b0;
            st_d.wr               = st_q.wr + PTR_ONE;
        end else if (push_i) begin
            st_d.err[st_q.wr - PTR_ONE].ovr = 1'b1;
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + PTR_ONE;
        end
        case ({accept, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_data_o = st_q.data[st_q.rd];
    assign head_err_o  = st_q.err[st_q.rd];
    assign count_o     = st_q.cnt;

    // R3: occupancy never exceeds the queue depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);

    // R3: a refused push leaves the occupancy unchanged
    a_r3_full_push_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && st_q.cnt == CNT_FULL && !pop_i) |=> $stable(count_o));

    // R2: a removal with no push lowers the occupancy by one
    a_r2_pop_lowers_count: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.cnt != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

endmodule

// File: rtl/rx_irq_logic.sv
module rx_irq_logic
    import rx_irq_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int THRESH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             thresh_en_i,
    input  logic             par_en_i,
    input  logic             rearm_i,
    input  logic             err_reset_i,
    input  logic             rd_i,
    input  logic             head_valid_i,
    input  rxi_err_t         head_err_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             pop_o,
    output logic             irq_pend_o,
    output logic [1:0]       vec_stat_o
);
    localparam logic [CNT_W-1:0] THR_CNT = CNT_W'(THRESH);

    typedef struct packed {
        logic lock;
        logic armed;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    rxi_mode_e  mode_e;
    logic       in_first, in_all, head_spec, lock_now, char_pend, spec_pend;
    rxi_vec_e   vec;

    always_comb begin
        mode_e    = rxi_mode_e'(mode_i);
        in_first  = (mode_e == MODE_FIRST);
        in_all    = (mode_e == MODE_ALL);
        head_spec = head_valid_i && (head_err_i.ovr || head_err_i.ferr ||
                    head_err_i.eof || (head_err_i.perr && par_en_i));
        lock_now  = in_first && (st_q.lock || head_spec);
        pop_o     = head_valid_i && (lock_now ? err_reset_i : rd_i);

        if (in_first) begin
            char_pend = st_q.armed && head_valid_i;
            spec_pend = lock_now;
        end else if (in_all) begin
            char_pend = thresh_en_i ? (count_i >= THR_CNT) : head_valid_i;
            spec_pend = head_spec;
        end else begin
            char_pend = 1'b0;
            spec_pend = 1'b0;
        end

        if (spec_pend)      vec = VEC_SPEC;
        else if (char_pend) vec = VEC_CHAR;
        else                vec = VEC_NONE;

        st_d      = st_q;
        st_d.lock = lock_now && !err_reset_i;
        if (!in_first || rearm_i) begin
            st_d.armed = 1'b1;
        end else if (pop_o) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{lock: 1'b0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pend_o = spec_pend || char_pend;
    assign vec_stat_o = vec;

    // R4: no pending interrupt while the mode is off
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF || mode_i == MODE_OFF_B) |-> !irq_pend_o);

    // R12: the code is always one of the three defined values
    a_r12_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        vec_stat_o != 2'b11);

    // R7: a locked exit entry keeps its flags into the next cycle
    a_r7_lock_holds_head: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && in_first && !err_reset_i) |=> ($stable(head_err_i) && head_valid_i));

    // R6: a removal in first-character mode disarms the character interrupt
    a_r6_no_char_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_first && pop_o && !rearm_i) |=> (mode_i != MODE_FIRST || vec_stat_o != VEC_CHAR));

endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
    import rx_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              push_perr_i,
    input  logic              push_ferr_i,
    input  logic              push_eof_i,
    input  logic              rd_i,
    input  logic [1:0]        mode_i,
    input  logic              thresh_en_i,
    input  logic              par_en_i,
    input  logic              rearm_i,
    input  logic              err_reset_i,
    output logic              head_valid_o,
    output logic [DATA_W-1:0] head_data_o,
    output logic [3:0]        head_err_o,
    output logic              irq_pend_o,
    output logic [1:0]        vec_stat_o
);
    localparam int CNT_W = $clog2(DEPTH+1);

    rxi_err_t         push_err, head_err;
    logic             pop;
    logic [CNT_W-1:0] count;

    assign push_err = '{eof: push_eof_i, ferr: push_ferr_i, ovr: 1'b0, perr: push_perr_i};

    rx_char_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .push_err_i  (push_err),
        .pop_i       (pop),
        .head_data_o (head_data_o),
        .head_err_o  (head_err),
        .count_o     (count)
    );

    rx_irq_logic #(.CNT_W(CNT_W), .THRESH(THRESH)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .thresh_en_i  (thresh_en_i),
        .par_en_i     (par_en_i),
        .rearm_i      (rearm_i),
        .err_reset_i  (err_reset_i),
        .rd_i         (rd_i),
        .head_valid_i (head_valid_o),
        .head_err_i   (head_err),
        .count_i      (count),
        .pop_o        (pop),
        .irq_pend_o   (irq_pend_o),
        .vec_stat_o   (vec_stat_o)
    );

    assign head_valid_o = (count != '0);
    assign head_err_o   = head_err;

    // R8: error reset while the exit is occupied and special in first mode removes it
    a_r8_reset_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (err_reset_i && mode_i == MODE_FIRST && vec_stat_o == VEC_SPEC && !push_i)
        |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: tb/rx_irq_ctrl_bench.sv
module rx_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 0, push_perr_i = 0, push_ferr_i = 0, push_eof_i = 0;
    logic [7:0] push_data_i = '0;
    logic       rd_i = 0, thresh_en_i = 0, par_en_i = 0, rearm_i = 0, err_reset_i = 0;
    logic [1:0] mode_i = 2'b00;
    logic       head_valid_o, irq_pend_o;
    logic [7:0] head_data_o;
    logic [3:0] head_err_o;
    logic [1:0] vec_stat_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [11:0] sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_irq_ctrl u_rx_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .push_perr_i(push_perr_i), .push_ferr_i(push_ferr_i), .push_eof_i(push_eof_i),
        .rd_i(rd_i), .mode_i(mode_i), .thresh_en_i(thresh_en_i), .par_en_i(par_en_i),
        .rearm_i(rearm_i), .err_reset_i(err_reset_i), .head_valid_o(head_valid_o),
        .head_data_o(head_data_o), .head_err_o(head_err_o), .irq_pend_o(irq_pend_o),
        .vec_stat_o(vec_stat_o)
    );

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(string tag, logic ip, logic [1:0] vec);
        chk({tag, " pend"}, 32'(irq_pend_o), 32'(ip));
        chk({tag, " vec"},  32'(vec_stat_o), 32'(vec));
    endtask

    // driver: one push, scoreboard follows the overrun rule (R3)
    task automatic drv_push(logic [7:0] d, logic pe, logic fe, logic ef, bit with_rd = 0);
        push_i = 1; push_data_i = d; push_perr_i = pe; push_ferr_i = fe; push_eof_i = ef;
        rd_i = with_rd;
        if (with_rd) begin
            chk("R2 head data", 32'(head_data_o), 32'(sb[0][7:0]));
            void'(sb.pop_front());
        end
        tick();
        push_i = 0; rd_i = 0; push_perr_i = 0; push_ferr_i = 0; push_eof_i = 0;
        if (sb.size() < 8) sb.push_back({1'b0 | ef, fe, 1'b0, pe, d});
        else sb[$][9] = 1'b1;
    endtask

    // monitor side: compare the exit entry with the scoreboard, then read
    task automatic host_rd(string tag, bit expect_pop);
        chk({tag, " head valid"}, 32'(head_valid_o), 32'(sb.size() != 0));
        chk({tag, " head data"},  32'(head_data_o),  32'(sb[0][7:0]));
        chk({tag, " head flags"}, 32'(head_err_o),   32'(sb[0][11:8]));
        rd_i = 1;
        tick();
        rd_i = 0;
        if (expect_pop) void'(sb.pop_front());
    endtask

    task automatic pulse_rearm();
        rearm_i = 1; tick(); rearm_i = 0;
    endtask

    task automatic pulse_err_reset();
        err_reset_i = 1; tick(); err_reset_i = 0;
        void'(sb.pop_front());
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 reset state
        chk("R1 empty", 32'(head_valid_o), 0);
        chk_irq("R1", 0, 2'b00);
        rst_n = 1;
        tick();

        // R4 mode off: no interrupt, reads still remove
        mode_i = 2'b00;
        drv_push(8'h11, 0, 0, 0);
        drv_push(8'h22, 0, 1, 0);
        drv_push(8'h33, 0, 0, 0);
        chk_irq("R4 off", 0, 2'b00);
        host_rd("R2 order", 1);
        host_rd("R2 order", 1);
        host_rd("R4 reads remove", 1);
        chk("R4 drained", 32'(head_valid_o), 0);

        // R5 character waiting at mode entry
        mode_i = 2'b11;
        drv_push(8'h44, 0, 0, 0);
        chk_irq("R4 mode 11", 0, 2'b00);
        mode_i = 2'b01;
        tick();
        chk_irq("R5 entry", 1, 2'b01);
        host_rd("R5", 1);
        chk_irq("R5 cleared", 0, 2'b00);

        // R6 no interrupt until rearm
        drv_push(8'h55, 0, 0, 0);
        drv_push(8'h66, 0, 0, 0);
        chk_irq("R6 disarmed", 0, 2'b00);
        pulse_rearm();
        chk_irq("R6 rearmed", 1, 2'b01);
        host_rd("R6", 1);
        chk_irq("R6 after read", 0, 2'b00);
        host_rd("R6", 1);

        // R7 / R8 lock on special condition
        drv_push(8'h77, 0, 0, 0);
        drv_push(8'h88, 0, 0, 1);
        pulse_rearm();
        chk_irq("R5 rearm", 1, 2'b01);
        host_rd("R7 plain", 1);
        chk_irq("R7 special", 1, 2'b10);
        host_rd("R7 locked", 0);
        chk("R7 reread data", 32'(head_data_o), 32'h88);
        chk("R7 reread flags", 32'(head_err_o), 32'h8);
        pulse_err_reset();
        chk("R8 removed", 32'(head_valid_o), 0);
        chk_irq("R8 unlocked", 0, 2'b00);

        // R11 parity only counts when enabled
        par_en_i = 0;
        drv_push(8'h99, 1, 0, 0);
        pulse_rearm();
        chk_irq("R11 parity ignored", 1, 2'b01);
        chk("R11 flag shown", 32'(head_err_o), 32'h1);
        host_rd("R11 not locked", 1);
        par_en_i = 1;
        drv_push(8'hAA, 1, 0, 0);
        chk_irq("R11 parity special", 1, 2'b10);
        pulse_err_reset();
        chk("R11 removed", 32'(head_valid_o), 0);

        // R9 / R12 every-character mode without threshold
        mode_i = 2'b10;
        drv_push(8'hBB, 0, 1, 0);
        drv_push(8'hCC, 0, 0, 0);
        chk_irq("R12 special wins", 1, 2'b10);
        host_rd("R9 no lock", 1);
        chk_irq("R9 plain", 1, 2'b01);
        host_rd("R9", 1);
        chk_irq("R9 empty", 0, 2'b00);

        // R10 threshold
        thresh_en_i = 1;
        drv_push(8'h01, 0, 0, 0);
        drv_push(8'h02, 0, 0, 0);
        drv_push(8'h03, 0, 0, 0);
        chk_irq("R10 three held", 0, 2'b00);
        drv_push(8'h04, 0, 0, 0);
        chk_irq("R10 four held", 1, 2'b01);
        host_rd("R10", 1);
        chk_irq("R10 below four", 0, 2'b00);
        for (int i = 0; i < 3; i++) host_rd("R10 drain", 1);

        // R3 full queue: collision then overrun
        thresh_en_i = 0;
        mode_i = 2'b00;
        for (int i = 0; i < 8; i++) drv_push(8'hD0 + 8'(i), 0, 0, 0);
        drv_push(8'hE0, 0, 0, 0, 1);
        drv_push(8'hE1, 0, 0, 0);
        for (int i = 0; i < 8; i++) host_rd("R3 drain", 1);
        chk("R3 empty", 32'(head_valid_o), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule